// File: doc/BRIEF.md
# Type-Tagged Operand Stack

This block is the evaluation stack of a stack-machine execution unit in which every entry carries a data word together with a 4-bit type tag. The two uppermost entries sit in registers (the top and the entry beneath it), so an operation can read both operands without a memory access. Any entry deeper than those two spills into a small tagged storage array that a stack pointer addresses. A pop that leaves the lower register empty while the array still holds entries reloads that register from the array in the following cycle. During that cycle the block reports busy and drops any command.

A push takes its tag either from an immediate field of the instruction or from a type value that a metadata lookup supplies. The block checks the tags of the entries an operation consumes. A binary operation accepts two entries that carry the same integer tag and replaces them with the externally computed result, which keeps that tag. A refused operation signals an exception code one cycle later and leaves the stack exactly as it was, so handler code can inspect it. The arithmetic and the handler are outside the block.

Top module: `tagstk_top`

## Requirements
- R1: While reset is asserted and after its release, depth is 0, busy is 0 and exc_valid is 0.
- R2: A command with cmd_op 0 pushes push_data with tag imm_tag. The previous top moves to the next position and depth rises by one.
- R3: A command with cmd_op 1 pushes push_data with tag meta_tag.
- R4: Entries deeper than the top two are kept in the storage array with their tags and come back in last-in first-out order, unchanged, up to DEPTH+2 entries in total.
- R5: cmd_op 2 pops the top entry. If the storage array held entries before the pop, busy is 1 for exactly the next cycle, every command in that cycle is ignored, and after that cycle next_data and next_tag show the entry reloaded from the array.
- R6: cmd_op 3, with both top entries tagged the same integer code (1 int32, 2 int64, 3 native int), replaces those two entries with alu_result under the same tag. Depth drops by one, and the reload rule of R5 applies.
- R7: cmd_op 3 on two entries whose tags differ, or that share a non-integer tag (4 float, 5 object reference, 6 managed pointer), raises exception code 1 (type mismatch).
- R8: A push whose selected tag is 0 or lies in 7..15 raises exception code 4 (invalid tag).
- R9: A push or duplicate when depth equals DEPTH+2 raises exception code 2 (overflow).
- R10: A pop or duplicate at depth 0, or a binary operation at depth below 2, raises exception code 3 (underflow).
- R11: cmd_op 4 pushes a copy of the top entry, data and tag. Other cmd_op values have no effect.
- R12: An exception shows as exc_valid high with its exc_code for exactly the cycle after the command. Depth, top and next entries stay as they were before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 push immediate tag, 1 push metadata tag, 2 pop, 3 binary operate, 4 duplicate |
| push_data | input | W | Data word for a push |
| imm_tag | input | 4 | Tag from the instruction immediate |
| meta_tag | input | 4 | Tag from the metadata lookup |
| alu_result | input | W | Result of the binary operation on top_data and next_data |
| busy | output | 1 | Reload cycle in progress; commands ignored |
| depth | output | clog2(DEPTH+3) | Number of entries on the stack |
| top_data | output | W | Data of the top entry |
| top_tag | output | 4 | Tag of the top entry |
| next_data | output | W | Data of the entry beneath the top |
| next_tag | output | 4 | Tag of the entry beneath the top |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 3 | 1 type, 2 overflow, 3 underflow, 4 invalid tag |

## Verification
Two functions can meet in one cycle: the reload of the lower register from the array, and a fresh command that would spill into that same array. The bench provokes this by issuing a push, and later a binary operation, in the busy cycle that follows a pop on a stack deeper than two. The cycle model in the bench says the command must vanish. The bench then checks on the next cycles that depth, both top entries and the popped-back deep entries match the model, and that no exception was raised. Overflow at full depth and the reload that follows a binary operation are also driven back to back.

// File: rtl/tagstk_pkg.sv
package tagstk_pkg;

  localparam int TAG_W = 4;

  // type tag codes
  localparam logic [TAG_W-1:0] TG_I32  = 4'd1;
  localparam logic [TAG_W-1:0] TG_I64  = 4'd2;
  localparam logic [TAG_W-1:0] TG_NINT = 4'd3;
  localparam logic [TAG_W-1:0] TG_FLT  = 4'd4;
  localparam logic [TAG_W-1:0] TG_OREF = 4'd5;
  localparam logic [TAG_W-1:0] TG_MPTR = 4'd6;

  // command codes
  localparam logic [2:0] OP_PSHI = 3'd0;
  localparam logic [2:0] OP_PSHM = 3'd1;
  localparam logic [2:0] OP_POP  = 3'd2;
  localparam logic [2:0] OP_BIN  = 3'd3;
  localparam logic [2:0] OP_DUP  = 3'd4;

  typedef enum logic [2:0] {
    EX_NONE   = 3'd0,
    EX_TYPE   = 3'd1,
    EX_OVF    = 3'd2,
    EX_UNF    = 3'd3,
    EX_BADTAG = 3'd4
  } exc_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_PUSH,
    ACT_POP,
    ACT_BIN,
    ACT_DUP
  } act_e;

  function automatic logic tag_legal(input logic [TAG_W-1:0] t);
    return (t >= TG_I32) && (t <= TG_MPTR);
  endfunction

  function automatic logic tag_integer(input logic [TAG_W-1:0] t);
    return (t == TG_I32) || (t == TG_I64) || (t == TG_NINT);
  endfunction

endpackage

// File: rtl/tagstk_rstsync.sv
module tagstk_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/tagstk_mem.sv
module tagstk_mem
  import tagstk_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [W-1:0]     wdata,
  input  logic [TAG_W-1:0] wtag,
  input  logic [AW-1:0]    raddr,
  output logic [W-1:0]     rdata,
  output logic [TAG_W-1:0] rtag
);

  localparam int CELL_W = W + TAG_W;

  logic [CELL_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic cell_en;
    logic [CELL_W-1:0] cell_q;
    assign cell_en = we && (waddr == AW'(i));
    always_ff @(posedge clk) begin
      if (cell_en) cell_q <= {wtag, wdata};
    end
    assign cells[i] = cell_q;
  end

  assign {rtag, rdata} = cells[raddr];

  // R4: a spill never targets a cell past the array
  always_ff @(posedge clk) begin
    if (we) begin
      a_r4_spill_in_range: assert (32'(waddr) < DEPTH)
        else $error("spill address out of range");
    end
  end

endmodule

// File: rtl/tagstk_check.sv
module tagstk_check
  import tagstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [CW-1:0]    cnt,
  input  logic [TAG_W-1:0] top_tag,
  input  logic [TAG_W-1:0] nxt_tag,
  input  logic [TAG_W-1:0] imm_tag,
  input  logic [TAG_W-1:0] meta_tag,
  output act_e             act,
  output exc_e             code,
  output logic [TAG_W-1:0] new_tag
);

  localparam int FULL = DEPTH + 2;

  logic full, empty, short2;
  assign full   = (cnt == CW'(FULL));
  assign empty  = (cnt == '0);
  assign short2 = (cnt < CW'(2));

  always_comb begin
    act     = ACT_NONE;
    code    = EX_NONE;
    new_tag = (cmd_op == OP_PSHM) ? meta_tag : imm_tag;
    if (cmd_valid) begin
      case (cmd_op)
        OP_PSHI, OP_PSHM: begin
          if (!tag_legal(new_tag)) code = EX_BADTAG;
          else if (full)           code = EX_OVF;
          else                     act  = ACT_PUSH;
        end
        OP_POP: begin
          if (empty) code = EX_UNF;
          else       act  = ACT_POP;
        end
        OP_BIN: begin
          if (short2)                                         code = EX_UNF;
          else if ((top_tag != nxt_tag) || !tag_integer(top_tag)) code = EX_TYPE;
          else                                                act  = ACT_BIN;
        end
        OP_DUP: begin
          if (empty)     code = EX_UNF;
          else if (full) code = EX_OVF;
          else           act  = ACT_DUP;
        end
        default: act = ACT_NONE;
      endcase
    end
  end

endmodule

// File: rtl/tagstk_top.sv
module tagstk_top
  import tagstk_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_op,
  input  logic [W-1:0]                 push_data,
  input  logic [3:0]                   imm_tag,
  input  logic [3:0]                   meta_tag,
  input  logic [W-1:0]                 alu_result,
  output logic                         busy,
  output logic [$clog2(DEPTH+3)-1:0]   depth,
  output logic [W-1:0]                 top_data,
  output logic [3:0]                   top_tag,
  output logic [W-1:0]                 next_data,
  output logic [3:0]                   next_tag,
  output logic                         exc_valid,
  output logic [2:0]                   exc_code
);

  localparam int CW  = $clog2(DEPTH + 3);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic srst_n;

  tagstk_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // state
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [SPW-1:0]   sp_q, sp_d;
  logic [W-1:0]     t_data_q, t_data_d, n_data_q, n_data_d;
  logic [TAG_W-1:0] t_tag_q, t_tag_d, n_tag_q, n_tag_d;
  logic             busy_q, busy_d;
  logic             exc_v_q, exc_v_d;
  exc_e             exc_c_q, exc_c_d;

  // checker
  act_e             act;
  exc_e             chk_code;
  logic [TAG_W-1:0] push_tag;

  tagstk_check #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .cmd_valid (cmd_valid && !busy_q),
    .cmd_op    (cmd_op),
    .cnt       (cnt_q),
    .top_tag   (t_tag_q),
    .nxt_tag   (n_tag_q),
    .imm_tag   (imm_tag),
    .meta_tag  (meta_tag),
    .act       (act),
    .code      (chk_code),
    .new_tag   (push_tag)
  );

  // spill storage
  logic             mem_we;
  logic [AW-1:0]    mem_waddr, mem_raddr;
  logic [W-1:0]     mem_rdata;
  logic [TAG_W-1:0] mem_rtag;

  assign mem_waddr = AW'(sp_q);
  assign mem_raddr = AW'(sp_q - 1'b1);

  tagstk_mem #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (n_data_q),
    .wtag  (n_tag_q),
    .raddr (mem_raddr),
    .rdata (mem_rdata),
    .rtag  (mem_rtag)
  );

  logic spill_needed, refill_pending;
  assign spill_needed   = (cnt_q >= CW'(2));
  assign refill_pending = (sp_q != '0);

  // next state
  always_comb begin
    cnt_d    = cnt_q;
    sp_d     = sp_q;
    t_data_d = t_data_q;
    t_tag_d  = t_tag_q;
    n_data_d = n_data_q;
    n_tag_d  = n_tag_q;
    busy_d   = 1'b0;
    exc_v_d  = 1'b0;
    exc_c_d  = EX_NONE;
    mem_we   = 1'b0;

    if (busy_q) begin
      n_data_d = mem_rdata;
      n_tag_d  = mem_rtag;
      sp_d     = sp_q - 1'b1;
    end else begin
      if (chk_code != EX_NONE) begin
        exc_v_d = 1'b1;
        exc_c_d = chk_code;
      end
      case (act)
        ACT_PUSH, ACT_DUP: begin
          if (spill_needed) begin
            mem_we = 1'b1;
            sp_d   = sp_q + 1'b1;
          end
          n_data_d = t_data_q;
          n_tag_d  = t_tag_q;
          if (act == ACT_PUSH) begin
            t_data_d = push_data;
            t_tag_d  = push_tag;
          end
          cnt_d = cnt_q + 1'b1;
        end
        ACT_POP: begin
          t_data_d = n_data_q;
          t_tag_d  = n_tag_q;
          cnt_d    = cnt_q - 1'b1;
          busy_d   = refill_pending;
        end
        ACT_BIN: begin
          t_data_d = alu_result;
          cnt_d    = cnt_q - 1'b1;
          busy_d   = refill_pending;
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q    <= '0;
      sp_q     <= '0;
      t_data_q <= '0;
      t_tag_q  <= '0;
      n_data_q <= '0;
      n_tag_q  <= '0;
      busy_q   <= 1'b0;
      exc_v_q  <= 1'b0;
      exc_c_q  <= EX_NONE;
    end else begin
      cnt_q    <= cnt_d;
      sp_q     <= sp_d;
      t_data_q <= t_data_d;
      t_tag_q  <= t_tag_d;
      n_data_q <= n_data_d;
      n_tag_q  <= n_tag_d;
      busy_q   <= busy_d;
      exc_v_q  <= exc_v_d;
      exc_c_q  <= exc_c_d;
    end
  end

  assign busy      = busy_q;
  assign depth     = cnt_q;
  assign top_data  = t_data_q;
  assign top_tag   = t_tag_q;
  assign next_data = n_data_q;
  assign next_tag  = n_tag_q;
  assign exc_valid = exc_v_q;
  assign exc_code  = exc_c_q;

  // assertions
  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q <= CW'(DEPTH + 2));

  a_r5_busy_single: assert property (@(posedge clk) disable iff (!srst_n)
    busy_q |=> !busy_q);

  a_r5_busy_has_pair: assert property (@(posedge clk) disable iff (!srst_n)
    busy_q |-> (cnt_q >= CW'(2)) && (sp_q != '0));

  a_r12_exc_coded: assert property (@(posedge clk) disable iff (!srst_n)
    exc_v_q |-> (exc_c_q != EX_NONE));

  a_r12_exc_holds_state: assert property (@(posedge clk) disable iff (!srst_n)
    exc_v_q |-> $stable(cnt_q) && $stable(t_tag_q) && $stable(sp_q));

  a_r8_top_tag_legal: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt_q != '0) |-> tag_legal(t_tag_q));

  a_r4_sp_tracks_depth: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt_q <= CW'(2)) |-> (sp_q == '0) || busy_q);

endmodule

// File: tb/tagstk_top_test.sv
module tagstk_top_test;

  localparam int W     = 32;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 3);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [W-1:0]  push_data = '0;
  logic [3:0]    imm_tag = '0;
  logic [3:0]    meta_tag = '0;
  logic [W-1:0]  alu_result = '0;
  logic          busy;
  logic [CW-1:0] depth;
  logic [W-1:0]  top_data, next_data;
  logic [3:0]    top_tag, next_tag;
  logic          exc_valid;
  logic [2:0]    exc_code;

  always #5 clk = ~clk;

  tagstk_top #(.W(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .push_data(push_data), .imm_tag(imm_tag), .meta_tag(meta_tag),
    .alu_result(alu_result), .busy(busy), .depth(depth),
    .top_data(top_data), .top_tag(top_tag), .next_data(next_data),
    .next_tag(next_tag), .exc_valid(exc_valid), .exc_code(exc_code)
  );

  int checks = 0;
  int fails  = 0;

  // reference model: q[0] is the top, each entry {tag, data}
  logic [35:0] q[$];
  bit          busy_m = 0;
  bit          exc_m  = 0;
  int          code_m = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal(logic [3:0] t);
    return (t >= 4'd1) && (t <= 4'd6);
  endfunction

  function automatic bit integ(logic [3:0] t);
    return (t >= 4'd1) && (t <= 4'd3);
  endfunction

  task automatic model(bit v, logic [2:0] op, logic [31:0] d, logic [3:0] it,
                       logic [3:0] mt, logic [31:0] alu);
    logic [3:0] t;
    int sz;
    code_m = 0;
    sz = q.size();
    if (busy_m) begin
      busy_m = 0;
    end else if (v) begin
      case (op)
        3'd0, 3'd1: begin
          t = (op == 3'd1) ? mt : it;
          if (!legal(t))             code_m = 4;
          else if (sz == DEPTH + 2)  code_m = 2;
          else                       q.push_front({t, d});
        end
        3'd2: begin
          if (sz == 0) code_m = 3;
          else begin
            void'(q.pop_front());
            busy_m = (sz >= 3);
          end
        end
        3'd3: begin
          if (sz < 2) code_m = 3;
          else if (q[0][35:32] != q[1][35:32] || !integ(q[0][35:32])) code_m = 1;
          else begin
            t = q[0][35:32];
            void'(q.pop_front());
            void'(q.pop_front());
            q.push_front({t, alu});
            busy_m = (sz >= 3);
          end
        end
        3'd4: begin
          if (sz == 0)              code_m = 3;
          else if (sz == DEPTH + 2) code_m = 2;
          else                      q.push_front(q[0]);
        end
        default: ;
      endcase
    end
    exc_m = (code_m != 0);
  endtask

  task automatic compare(string req);
    chk(int'(depth) == q.size(), req, "depth", longint'(depth), longint'(q.size()));
    chk(busy == busy_m, req, "busy", longint'(busy), longint'(busy_m));
    chk(exc_valid == exc_m, "R12", "exc_valid", longint'(exc_valid), longint'(exc_m));
    if (exc_m)
      chk(int'(exc_code) == code_m, req, "exc_code", longint'(exc_code), longint'(code_m));
    if (q.size() >= 1)
      chk({top_tag, top_data} == q[0], req, "top", longint'({top_tag, top_data}), longint'(q[0]));
    if (q.size() >= 2 && !busy_m)
      chk({next_tag, next_data} == q[1], req, "next", longint'({next_tag, next_data}), longint'(q[1]));
  endtask

  task automatic step(bit v, logic [2:0] op, logic [31:0] d, logic [3:0] it,
                      logic [3:0] mt, logic [31:0] alu, string req);
    cmd_valid  = v;
    cmd_op     = op;
    push_data  = d;
    imm_tag    = it;
    meta_tag   = mt;
    alu_result = alu;
    model(v, op, d, it, mt, alu);
    @(negedge clk);
    cmd_valid = 1'b0;
    compare(req);
  endtask

  task automatic idle(string req);
    step(1'b0, 3'd0, 32'h0, 4'd0, 4'd0, 32'h0, req);
  endtask

  task automatic push_i(logic [31:0] d, logic [3:0] t, string req);
    step(1'b1, 3'd0, d, t, 4'd0, 32'h0, req);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(depth == '0 && !busy && !exc_valid, "R1", "reset outputs",
        longint'({busy, exc_valid, depth}), 0);
    rst_n = 1'b1;
    repeat (3) idle("R1");

    // R2, R3, R4: pushes with both tag sources, spill past two
    push_i(32'h11, 4'd1, "R2");
    step(1'b1, 3'd1, 32'h22, 4'd9, 4'd2, 32'h0, "R3");
    push_i(32'h33, 4'd4, "R4");
    push_i(32'h44, 4'd5, "R4");

    // R5: pop with reload, command during busy ignored
    step(1'b1, 3'd2, 32'h0, 4'd0, 4'd0, 32'h0, "R5");
    push_i(32'h99, 4'd1, "R5");
    idle("R5");

    // R7: float over int64
    step(1'b1, 3'd3, 32'h0, 4'd0, 4'd0, 32'hAA, "R7");
    step(1'b1, 3'd2, 32'h0, 4'd0, 4'd0, 32'h0, "R5");
    step(1'b1, 3'd3, 32'h0, 4'd0, 4'd0, 32'hAB, "R5");
    idle("R5");
    step(1'b1, 3'd3, 32'h0, 4'd0, 4'd0, 32'hAC, "R7");

    // R6: int64 pair, reload after a binary operation
    push_i(32'h55, 4'd2, "R2");
    step(1'b1, 3'd3, 32'h0, 4'd0, 4'd0, 32'h77, "R6");
    idle("R6");

    // R11: duplicate and unused opcodes
    step(1'b1, 3'd4, 32'h0, 4'd0, 4'd0, 32'h0, "R11");
    for (int k = 5; k < 8; k++) step(1'b1, 3'(k), 32'h5, 4'd1, 4'd1, 32'h0, "R11");

    // R8: invalid tags on both sources
    push_i(32'h66, 4'd0, "R8");
    push_i(32'h66, 4'd9, "R8");
    step(1'b1, 3'd1, 32'h66, 4'd1, 4'd15, 32'h0, "R8");

    // R4, R9: fill to the limit, then overflow
    for (int k = 0; k < DEPTH + 2; k++) push_i(32'h100 + k, 4'(1 + k % 6), "R4");
    push_i(32'h200, 4'd1, "R9");
    step(1'b1, 3'd4, 32'h0, 4'd0, 4'd0, 32'h0, "R9");

    // R4, R5: drain, issuing each pop and then a binary op during busy
    for (int k = 0; k < DEPTH + 4; k++) begin
      step(1'b1, 3'd2, 32'h0, 4'd0, 4'd0, 32'h0, "R4");
      if (busy_m) step(1'b1, 3'd3, 32'h0, 4'd0, 4'd0, 32'hEE, "R5");
    end

    // R10: underflow cases
    step(1'b1, 3'd2, 32'h0, 4'd0, 4'd0, 32'h0, "R10");
    step(1'b1, 3'd3, 32'h0, 4'd0, 4'd0, 32'h0, "R10");
    step(1'b1, 3'd4, 32'h0, 4'd0, 4'd0, 32'h0, "R10");
    push_i(32'h1, 4'd3, "R2");
    step(1'b1, 3'd3, 32'h0, 4'd0, 4'd0, 32'h0, "R10");

    // R6: native int pair; R7: equal non-integer pair
    push_i(32'h2, 4'd3, "R2");
    step(1'b1, 3'd3, 32'h0, 4'd0, 4'd0, 32'h3, "R6");
    step(1'b1, 3'd1, 32'h4, 4'd0, 4'd4, 32'h0, "R3");
    step(1'b1, 3'd1, 32'h5, 4'd0, 4'd4, 32'h0, "R3");
    step(1'b1, 3'd3, 32'h0, 4'd0, 4'd0, 32'h9, "R7");
    repeat (2) idle("R12");

    summary();
  end

endmodule